// File: doc/BRIEF.md
# Keyed configuration port controller

This block gives software a two-address window onto a set of configuration registers over a simple I/O bus with separate read and write strobes. One address acts as an index port that selects a register. The next address up acts as a data port that reads or writes the selected register. A strap input, sampled during reset, decides where the pair of addresses sits.

The window stays locked after reset. Software opens it by writing the enter key twice in a row to the index port and closes it again with an exit key. While the window is open, indices below 0x30 reach global registers: a self-clearing soft reset, a device-select number and four read-only identification bytes. Indices from 0x30 upward reach a small per-device register array. The device-select number picks which array answers.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the window is locked, the selected index is 0x00, the device-select number is 0x00, every array register is 0x00 and bus_rdata reads 0xFF.
- R2: When strap_sel is 1 during reset, the index port is at 0x004E and the data port is at 0x004F. When strap_sel is 0, they are at 0x002E and 0x002F. Keys written to the other pair have no effect.
- R3: The window opens only after two index-port writes of 0x87 with no other index-port write between them. Any other byte written in between restarts the sequence, and that byte does not count as a first key.
- R4: While the window is open, an index-port write of 0xAA locks it. The selected index keeps its value across the lock.
- R5: While the window is locked, data-port writes change nothing, and reads of either port return 0xFF.
- R6: While the window is open, an index-port write of any byte other than 0xAA becomes the selected index. An index-port read returns the selected index.
- R7: Index 0x07 holds an 8-bit device-select number that can be read and written. A value of NUM_DEV (default 4) or more selects no array: array reads return 0x00 and array writes are dropped.
- R8: Indices 0x30 to 0x30+BANK_REGS-1 (default 0x37) reach one 8-bit register of the array picked by the device-select number. Each device has its own storage. Other indices from 0x30 up read 0x00.
- R9: Indices 0x20, 0x21, 0x23 and 0x24 return CHIP_ID[15:8], CHIP_ID[7:0], VENDOR_ID[15:8] and VENDOR_ID[7:0] (defaults 0xC0, 0xDE, 0x5A, 0x17). Writes to these indices are ignored.
- R10: A data write with bit 0 set to index 0x02 raises the soft reset bit for exactly one cycle. In the following cycle the bit clears the device-select number and every array register to 0x00. The lock state and the selected index are left unchanged, and index 0x02 reads back 0x00 once the bit has cleared.
- R11: bus_rdata is updated only at a clock edge where bus_rd is high and bus_addr matches one of the two ports. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_sel | input | 1 | Port pair select, sampled while rst_n is low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered at the edge where bus_rd is sampled |

## Verification
The key detector is tested with a wrong byte between two enter keys. A detector that did not restart, or that counted the wrong byte as a first key, would open early, and the following data read would return real data instead of 0xFF. A device-select value beyond the device count is written while a bank register is being written. A design that decoded only the low bits of that value would overwrite another device's register, and a later read would show the stray value. The soft reset test checks that the device-select number and the array clear while the window stays open and the index is kept. A data-port write made while the window is locked must not change the register the retained index points at.

// File: rtl/cfg_port_pkg.sv
// Shared constants and types for the keyed configuration port controller.
// Assumes 8-bit index and data bytes on the configuration bus.
package cfg_port_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_ENTER     = 8'h87;
    localparam logic [7:0] KEY_EXIT      = 8'hAA;
    localparam logic [7:0] IDX_SWRST     = 8'h02;
    localparam logic [7:0] IDX_DEVSEL    = 8'h07;
    localparam logic [7:0] IDX_CHIP_HI   = 8'h20;
    localparam logic [7:0] IDX_CHIP_LO   = 8'h21;
    localparam logic [7:0] IDX_VEND_HI   = 8'h23;
    localparam logic [7:0] IDX_VEND_LO   = 8'h24;
    localparam logic [7:0] IDX_BANK_BASE = 8'h30;
    localparam logic [7:0] LOCKED_READ   = 8'hFF;

endpackage

// File: rtl/cfg_key_fsm.sv
// Lock/unlock state machine and index register.
// Every index-port write drives it. While the window is locked or half
// keyed it only watches for the key bytes. While open, it latches the
// byte as the selected index unless the byte is the exit key.
// Assumes idx_wr is a single-cycle qualified index-port write.
module cfg_key_fsm
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] sel_index
);

    key_state_t state_q;

    // Purpose: advance the key sequence and hold the selected index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= KS_LOCKED;
            sel_index <= 8'h00;
        end else if (idx_wr) begin
            case (state_q)
                KS_LOCKED: state_q <= (wdata == KEY_ENTER) ? KS_HALF : KS_LOCKED;
                KS_HALF:   state_q <= (wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
                KS_OPEN: begin
                    if (wdata == KEY_EXIT) state_q <= KS_LOCKED;
                    else                   sel_index <= wdata;
                end
                default:   state_q <= KS_LOCKED;
            endcase
        end
    end

    // Purpose: flag the open window for the decode logic.
    assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/cfg_glob_regs.sv
// Global register set below index 0x30: soft reset, device select and
// the identification bytes. The soft reset bit is a one-cycle pulse.
// Assumes wr_en is already qualified by an open window and data-port address.
module cfg_glob_regs
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] CHIP_ID   = 16'hC0DE,
    parameter logic [15:0] VENDOR_ID = 16'h5A17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] devsel,
    output logic       swrst,
    output logic [7:0] rd_val
);

    // Purpose: hold the device select number and generate the soft reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel <= 8'h00;
            swrst  <= 1'b0;
        end else begin
            swrst <= 1'b0;
            if (swrst)
                devsel <= 8'h00;
            else if (wr_en && index == IDX_DEVSEL)
                devsel <= wdata;
            if (wr_en && index == IDX_SWRST && wdata[0] && !swrst)
                swrst <= 1'b1;
        end
    end

    // Purpose: read multiplexer for the global indices.
    always_comb begin
        case (index)
            IDX_SWRST:   rd_val = {7'b0, swrst};
            IDX_DEVSEL:  rd_val = devsel;
            IDX_CHIP_HI: rd_val = CHIP_ID[15:8];
            IDX_CHIP_LO: rd_val = CHIP_ID[7:0];
            IDX_VEND_HI: rd_val = VENDOR_ID[15:8];
            IDX_VEND_LO: rd_val = VENDOR_ID[7:0];
            default:     rd_val = 8'h00;
        endcase
    end

endmodule

// File: rtl/cfg_bank_regs.sv
// Per-device register arrays, one generated per device.
// Assumes wr_en is already qualified by a valid device select and an
// in-range offset. clr is the soft reset pulse and takes priority.
module cfg_bank_regs #(
    parameter int NUM_DEV   = 4,
    parameter int BANK_REGS = 8,
    localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int OFF_W    = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] dev_sel,
    input  logic [OFF_W-1:0] offset,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_val
);

    logic [7:0] dev_rd [NUM_DEV];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [7:0] regs_q [BANK_REGS];

        // Purpose: storage for one device's registers.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                for (int r = 0; r < BANK_REGS; r++) regs_q[r] <= 8'h00;
            end else if (wr_en && dev_sel == DEV_W'(d)) begin
                regs_q[offset] <= wdata;
            end
        end

        // Purpose: this device's read value at the current offset.
        assign dev_rd[d] = regs_q[offset];
    end

    // Purpose: pick the selected device's read value.
    assign rd_val = dev_rd[dev_sel];

endmodule

// File: rtl/cfg_port_ctrl.sv
// Keyed configuration port controller top.
// Decodes the strapped index/data port pair, gates data access on the
// key state and registers read data at the edge where bus_rd is sampled.
// Assumes bus_wr and bus_rd are never high in the same cycle and that
// strap_sel is stable while rst_n is low.
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_DEF = ADDR_W'(16'h004E),
    parameter logic [ADDR_W-1:0] BASE_ALT = ADDR_W'(16'h002E),
    parameter int              NUM_DEV   = 4,
    parameter int              BANK_REGS = 8,
    parameter logic [15:0]     CHIP_ID   = 16'hC0DE,
    parameter logic [15:0]     VENDOR_ID = 16'h5A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);

    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

    logic              strap_q;
    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] data_addr;
    logic              idx_wr;
    logic              data_wr;
    logic              unlocked;
    logic [7:0]        sel_index;
    logic [7:0]        devsel;
    logic              swrst;
    logic [7:0]        glob_rd;
    logic [7:0]        bank_rd;
    logic [7:0]        bank_off;
    logic              bank_range;
    logic              bank_hit;
    logic              dev_ok;
    logic [7:0]        data_rd;

    // Purpose: capture the strap while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_sel;
    end

    // Purpose: port address decode and access qualification.
    assign idx_addr   = strap_q ? BASE_DEF : BASE_ALT;
    assign data_addr  = idx_addr + ADDR_W'(1);
    assign idx_wr     = bus_wr && (bus_addr == idx_addr);
    assign data_wr    = bus_wr && (bus_addr == data_addr) && unlocked;
    assign bank_off   = sel_index - IDX_BANK_BASE;
    assign bank_range = (sel_index >= IDX_BANK_BASE) && (bank_off < 8'(BANK_REGS));
    assign dev_ok     = (devsel < 8'(NUM_DEV));
    assign bank_hit   = bank_range && dev_ok;

    cfg_key_fsm u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .wdata     (bus_wdata),
        .unlocked  (unlocked),
        .sel_index (sel_index)
    );

    cfg_glob_regs #(
        .CHIP_ID   (CHIP_ID),
        .VENDOR_ID (VENDOR_ID)
    ) u_glob (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (data_wr && (sel_index < IDX_BANK_BASE)),
        .index  (sel_index),
        .wdata  (bus_wdata),
        .devsel (devsel),
        .swrst  (swrst),
        .rd_val (glob_rd)
    );

    cfg_bank_regs #(
        .NUM_DEV   (NUM_DEV),
        .BANK_REGS (BANK_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (swrst),
        .wr_en   (data_wr && bank_hit),
        .dev_sel (devsel[DEV_W-1:0]),
        .offset  (bank_off[OFF_W-1:0]),
        .wdata   (bus_wdata),
        .rd_val  (bank_rd)
    );

    // Purpose: choose the data-port read value for the selected index.
    always_comb begin
        if (sel_index < IDX_BANK_BASE) data_rd = glob_rd;
        else if (bank_hit)             data_rd = bank_rd;
        else                           data_rd = 8'h00;
    end

    // Purpose: register read data for accesses to either port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= LOCKED_READ;
        end else if (bus_rd) begin
            if (bus_addr == idx_addr)
                bus_rdata <= unlocked ? sel_index : LOCKED_READ;
            else if (bus_addr == data_addr)
                bus_rdata <= unlocked ? data_rd : LOCKED_READ;
        end
    end

endmodule

// File: rtl/cfg_port_ctrl_chk.sv
// Protocol checker for cfg_port_ctrl, bound onto every instance.
// Watches the bus ports together with the key state and soft reset pulse.
module cfg_port_ctrl_chk #(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] CHIP_ID = 16'hC0DE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [ADDR_W-1:0] idx_addr,
    input logic [ADDR_W-1:0] data_addr,
    input logic              unlocked,
    input logic [7:0]        sel_index,
    input logic              swrst
);

    // R5
    locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unlocked && (bus_addr == data_addr || bus_addr == idx_addr))
        |=> (bus_rdata == 8'hFF));

    // R3
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == idx_addr && bus_wdata == 8'h87));

    // R4
    exit_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_addr == idx_addr && bus_wdata == 8'hAA) |=> !unlocked);

    // R10
    swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !swrst);

    // R9
    chip_id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_rd && bus_addr == data_addr && sel_index == 8'h20)
        |=> (bus_rdata == CHIP_ID[15:8]));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .CHIP_ID (CHIP_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .idx_addr  (idx_addr),
    .data_addr (data_addr),
    .unlocked  (unlocked),
    .sel_index (sel_index),
    .swrst     (swrst)
);

// File: tb/cfg_port_ctrl_bench.sv
// Self-checking bench for cfg_port_ctrl: vector table walk, then directed tests.
module cfg_port_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDX_DEF = 16'h004E;
    localparam logic [15:0] DAT_DEF = 16'h004F;
    localparam logic [15:0] IDX_ALT = 16'h002E;
    localparam logic [15:0] DAT_ALT = 16'h002F;

    // vector: op[21:20] (0 index wr, 1 data wr, 2 data rd, 3 index rd), data[19:12], expect[11:4], req[3:0]
    localparam int NVEC = 42;
    localparam logic [21:0] VEC [NVEC] = '{
        {2'd0, 8'h07, 8'h00, 4'd6},   // R6 select device number
        {2'd3, 8'h00, 8'h07, 4'd6},   // R6 index readback
        {2'd2, 8'h00, 8'h00, 4'd7},   // R7 device number resets to 0
        {2'd1, 8'h01, 8'h00, 4'd7},
        {2'd2, 8'h00, 8'h01, 4'd7},   // R7
        {2'd0, 8'h30, 8'h00, 4'd8},
        {2'd1, 8'h5A, 8'h00, 4'd8},   // device 1 reg 0
        {2'd0, 8'h07, 8'h00, 4'd8},
        {2'd1, 8'h02, 8'h00, 4'd8},
        {2'd0, 8'h30, 8'h00, 4'd8},
        {2'd2, 8'h00, 8'h00, 4'd8},   // R8 device 2 separate
        {2'd1, 8'hC3, 8'h00, 4'd8},
        {2'd2, 8'h00, 8'hC3, 4'd8},   // R8
        {2'd0, 8'h07, 8'h00, 4'd8},
        {2'd1, 8'h01, 8'h00, 4'd8},
        {2'd0, 8'h30, 8'h00, 4'd8},
        {2'd2, 8'h00, 8'h5A, 4'd8},   // R8 device 1 kept
        {2'd0, 8'h37, 8'h00, 4'd8},
        {2'd1, 8'h11, 8'h00, 4'd8},
        {2'd2, 8'h00, 8'h11, 4'd8},   // R8 top offset
        {2'd0, 8'h38, 8'h00, 4'd8},
        {2'd1, 8'h44, 8'h00, 4'd8},
        {2'd2, 8'h00, 8'h00, 4'd8},   // R8 beyond array
        {2'd0, 8'h07, 8'h00, 4'd7},
        {2'd1, 8'h09, 8'h00, 4'd7},
        {2'd0, 8'h30, 8'h00, 4'd7},
        {2'd2, 8'h00, 8'h00, 4'd7},   // R7 out-of-range device reads 0
        {2'd1, 8'h66, 8'h00, 4'd7},
        {2'd0, 8'h07, 8'h00, 4'd7},
        {2'd1, 8'h01, 8'h00, 4'd7},
        {2'd0, 8'h30, 8'h00, 4'd7},
        {2'd2, 8'h00, 8'h5A, 4'd7},   // R7 dropped write
        {2'd0, 8'h20, 8'h00, 4'd9},
        {2'd2, 8'h00, 8'hC0, 4'd9},   // R9
        {2'd1, 8'h00, 8'h00, 4'd9},
        {2'd2, 8'h00, 8'hC0, 4'd9},   // R9 read-only
        {2'd0, 8'h21, 8'h00, 4'd9},
        {2'd2, 8'h00, 8'hDE, 4'd9},
        {2'd0, 8'h23, 8'h00, 4'd9},
        {2'd2, 8'h00, 8'h5A, 4'd9},
        {2'd0, 8'h24, 8'h00, 4'd9},
        {2'd2, 8'h00, 8'h17, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_sel = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [7:0] rv;
    logic [15:0] ip = IDX_DEF;
    logic [15:0] dp = DAT_DEF;

    cfg_port_ctrl u_cfg_port_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_sel (strap_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; strap_sel = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        check("R1 reset rdata", bus_rdata, 8'hFF);
        rd(DAT_DEF, rv); check("R1 locked after reset", rv, 8'hFF);

        // R3 single key is not enough
        wr(IDX_DEF, 8'h87);
        rd(DAT_DEF, rv); check("R3 one key", rv, 8'hFF);
        wr(IDX_DEF, 8'h87);
        rd(IDX_DEF, rv); check("R1 index resets to 0", rv, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] dv, ev;
            op = VEC[i][21:20]; dv = VEC[i][19:12]; ev = VEC[i][11:4];
            case (op)
                2'd0: wr(ip, dv);
                2'd1: wr(dp, dv);
                2'd2: begin rd(dp, rv); check($sformatf("R%0d vec %0d", VEC[i][3:0], i), rv, ev); end
                default: begin rd(ip, rv); check($sformatf("R%0d vec %0d", VEC[i][3:0], i), rv, ev); end
            endcase
        end

        // R4 and R5: lock with index at device number, locked write ignored
        wr(IDX_DEF, 8'h07);
        wr(IDX_DEF, 8'hAA);
        rd(DAT_DEF, rv); check("R4 relocked data read", rv, 8'hFF);
        wr(DAT_DEF, 8'h03);
        rd(IDX_DEF, rv); check("R5 locked index read", rv, 8'hFF);
        wr(IDX_DEF, 8'h87); wr(IDX_DEF, 8'h87);
        rd(DAT_DEF, rv); check("R5 locked write ignored", rv, 8'h01);
        rd(IDX_DEF, rv); check("R4 index kept over lock", rv, 8'h07);

        // R3 broken key sequence
        wr(IDX_DEF, 8'hAA);
        wr(IDX_DEF, 8'h87); wr(IDX_DEF, 8'h12); wr(IDX_DEF, 8'h87);
        rd(DAT_DEF, rv); check("R3 restart after wrong byte", rv, 8'hFF);
        wr(IDX_DEF, 8'h87);
        rd(DAT_DEF, rv); check("R3 opens on second key", rv, 8'h01);

        // R10 soft reset
        wr(IDX_DEF, 8'h30);
        rd(DAT_DEF, rv); check("R10 baseline", rv, 8'h5A);
        wr(IDX_DEF, 8'h02);
        wr(DAT_DEF, 8'h01);
        @(negedge clk);
        rd(DAT_DEF, rv); check("R10 bit self-clears", rv, 8'h00);
        wr(IDX_DEF, 8'h07);
        rd(DAT_DEF, rv); check("R10 device number cleared", rv, 8'h00);
        wr(DAT_DEF, 8'h01);
        wr(IDX_DEF, 8'h30);
        rd(DAT_DEF, rv); check("R10 array cleared", rv, 8'h00);
        rd(IDX_DEF, rv); check("R10 index and lock kept", rv, 8'h30);

        // R11 read data holds between reads
        wr(IDX_DEF, 8'h07);
        rd(DAT_DEF, rv);
        wr(DAT_DEF, 8'h05);
        @(negedge clk); @(negedge clk);
        check("R11 rdata holds", bus_rdata, 8'h01);

        // R2 alternate port pair
        do_reset(1'b0);
        ip = IDX_ALT; dp = DAT_ALT;
        wr(IDX_DEF, 8'h87); wr(IDX_DEF, 8'h87);
        rd(IDX_ALT, rv); check("R2 default pair inactive", rv, 8'hFF);
        wr(IDX_ALT, 8'h87); wr(IDX_ALT, 8'h87);
        rd(IDX_ALT, rv); check("R2 alternate pair opens", rv, 8'h00);
        wr(IDX_ALT, 8'h23);
        rd(DAT_ALT, rv); check("R2 alternate data port", rv, 8'h5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule